// File: doc/BRIEF.md
# Privileged Wait and Fence Trap Decider

This block decides, for one privileged instruction at a time, whether the instruction may run or must trap. It covers five instruction kinds: wait-for-interrupt, wait-on-reservation without a timeout, the address-translation fence, the hypervisor fence and the hypervisor guest-physical fence. The core's execute stage presents a one-hot instruction kind together with its current privilege level, its virtualization state, whether supervisor mode is implemented, and four trap-control bits. The machine status register supplies two of them: wait-trap and translation-trap. The hypervisor status register supplies the other two: virtual wait-trap and virtual translation-trap.

The answer is a one-hot verdict with three possible values. The instruction either executes (halt for the wait kinds, flush request for the fences), raises an illegal-instruction trap, or raises a virtual-instruction trap. Each instruction kind has its own order of precedence between the two traps. The decision logic is purely combinational. A parameter selects whether the verdict leaves through one register stage (the default) or leaves directly. Halting, wakeup and the translation cache itself are handled elsewhere.

Top module: `priv_wait_fence_decider`

## Requirements
- R1: Privilege encoding: 2'b00 is user, 2'b01 is supervisor and 2'b11 is machine. Instruction kind bit 0 is wait-for-interrupt, bit 1 is wait-on-reservation, bit 2 is the translation fence, bit 3 is the hypervisor fence and bit 4 is the hypervisor guest fence. While reset is high and on the cycle after it, every response output is 0.
- R2: With the default register stage, a request sampled on one rising edge is answered on the outputs after that edge. Exactly one of rsp_exec, rsp_illegal and rsp_virtual is 1 when rsp_valid is 1, and all three are 0 when rsp_valid is 0.
- R3: Wait-for-interrupt is illegal in either of two cases. The first is wait-trap set while in supervisor mode, or while in user mode when supervisor mode is absent. The second is supervisor mode present while in non-virtualized user mode.
- R4: When R3 does not apply, wait-for-interrupt gives a virtual-instruction trap if virtualized and either in user mode, or in supervisor mode with virtual wait-trap set. In every other case it executes.
- R5: Wait-on-reservation gives a virtual-instruction trap when virtualized in supervisor or user mode with virtual wait-trap set and wait-trap clear. Otherwise it is illegal when not in machine mode with wait-trap set. Otherwise it executes.
- R6: The translation fence is illegal when not virtualized and either in user mode, or in supervisor mode with translation-trap set.
- R7: When R6 does not apply, the translation fence gives a virtual-instruction trap if virtualized and either in user mode or with virtual translation-trap set. Otherwise it executes.
- R8: The hypervisor fence gives a virtual-instruction trap whenever virtualized. Otherwise it executes in machine or supervisor mode and is illegal in user mode.
- R9: The hypervisor guest fence is illegal in non-virtualized supervisor mode with translation-trap set. This check comes before everything else. When it does not apply, the hypervisor guest fence follows R8.
- R10: A request whose kind has no bit set or more than one bit set gets the illegal-instruction verdict.
- R11: The reserved privilege encoding 2'b10 is treated exactly like machine mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A decision is requested this cycle |
| req_kind | input | 5 | One-hot instruction kind (R1 bit order) |
| cur_priv | input | 2 | Current privilege level |
| virt_on | input | 1 | Core is running virtualized |
| has_smode | input | 1 | Supervisor mode is implemented |
| ms_wait_trap | input | 1 | Machine status wait-trap bit |
| ms_xlat_trap | input | 1 | Machine status translation-trap bit |
| hs_wait_trap | input | 1 | Hypervisor status virtual wait-trap bit |
| hs_xlat_trap | input | 1 | Hypervisor status virtual translation-trap bit |
| rsp_valid | output | 1 | Verdict is valid |
| rsp_exec | output | 1 | Instruction executes (halt or flush) |
| rsp_illegal | output | 1 | Illegal-instruction trap |
| rsp_virtual | output | 1 | Virtual-instruction trap |

## Verification
The hard cases are those where an illegal-instruction condition and a virtual-instruction condition hold in the same cycle. Only the precedence of the selected kind decides which trap wins. Examples are wait-on-reservation with both virtual wait-trap and wait-trap set, the guest fence in supervisor mode with translation-trap set, and wait-for-interrupt in virtualized supervisor mode with both wait bits set. The bench provokes these by enumerating every kind, privilege encoding, virtualization, supervisor-present and trap-bit combination. Each result is judged against a reference function in the bench that encodes each kind's precedence. Random requests, including malformed kinds and idle cycles, follow the enumeration.

// File: rtl/twd_pkg.sv
package twd_pkg;

    localparam int KIND_W     = 5;
    localparam int KIND_WFI   = 0;
    localparam int KIND_WRS   = 1;
    localparam int KIND_FENCE = 2;
    localparam int KIND_HFNC  = 3;
    localparam int KIND_HGFNC = 4;

    typedef enum logic [1:0] {
        PRIV_USER    = 2'b00,
        PRIV_SUPER   = 2'b01,
        PRIV_RSVD    = 2'b10,
        PRIV_MACHINE = 2'b11
    } priv_e;

    // Packed verdict: exec is bit 0, illegal bit 1, virtual bit 2.
    typedef struct packed {
        logic virt_trap;
        logic illegal;
        logic exec;
    } verdict_t;

    // Decoded privilege and virtualization context.
    typedef struct packed {
        logic m;
        logic s;
        logic u;
        logic v;
    } ctx_t;

    localparam verdict_t VERDICT_NONE = '{virt_trap: 1'b0, illegal: 1'b0, exec: 1'b0};

    function automatic ctx_t decode_ctx(input logic [1:0] priv, input logic virt);
        ctx_t c;
        c.u = (priv == PRIV_USER);
        c.s = (priv == PRIV_SUPER);
        c.m = priv[1];           // reserved encoding folds into machine
        c.v = virt;
        return c;
    endfunction

    // Illegal check outranks virtual check.
    function automatic verdict_t ill_first(input logic ill, input logic vrt);
        verdict_t r;
        r.illegal   = ill;
        r.virt_trap = !ill && vrt;
        r.exec      = !ill && !vrt;
        return r;
    endfunction

    // Virtual check outranks illegal check.
    function automatic verdict_t virt_first(input logic vrt, input logic ill);
        verdict_t r;
        r.virt_trap = vrt;
        r.illegal   = !vrt && ill;
        r.exec      = !vrt && !ill;
        return r;
    endfunction

    function automatic logic is_onehot(input logic [KIND_W-1:0] k);
        return (k != '0) && ((k & (k - 1'b1)) == '0);
    endfunction

endpackage

// File: rtl/twd_wait_unit.sv
module twd_wait_unit
    import twd_pkg::*;
(
    input  ctx_t     ctx,
    input  logic     has_smode,
    input  logic     ms_wait_trap,
    input  logic     hs_wait_trap,
    output verdict_t wfi_verdict,
    output verdict_t wrs_verdict
);

    logic wfi_ill;
    logic wfi_vrt;
    logic wrs_ill;
    logic wrs_vrt;

    // Wait-for-interrupt: illegal check first.
    always_comb begin
        wfi_ill = ((ctx.s || (!has_smode && ctx.u)) && ms_wait_trap)
                || (has_smode && ctx.u && !ctx.v);
        wfi_vrt = ctx.v && (ctx.u || (ctx.s && hs_wait_trap));
        wfi_verdict = ill_first(wfi_ill, wfi_vrt);
    end

    // Wait-on-reservation: virtual check first.
    always_comb begin
        wrs_vrt = ctx.v && (ctx.s || ctx.u) && hs_wait_trap && !ms_wait_trap;
        wrs_ill = !ctx.m && ms_wait_trap;
        wrs_verdict = virt_first(wrs_vrt, wrs_ill);
    end

endmodule

// File: rtl/twd_fence_unit.sv
module twd_fence_unit
    import twd_pkg::*;
(
    input  ctx_t     ctx,
    input  logic     ms_xlat_trap,
    input  logic     hs_xlat_trap,
    output verdict_t fence_verdict,
    output verdict_t hfence_verdict,
    output verdict_t hgfence_verdict
);

    logic fence_ill;
    logic fence_vrt;
    logic hf_ok;
    logic hg_pre_ill;

    // Translation fence: illegal check first.
    always_comb begin
        fence_ill = !ctx.v && (ctx.u || (ctx.s && ms_xlat_trap));
        fence_vrt = ctx.v && (ctx.u || hs_xlat_trap);
        fence_verdict = ill_first(fence_ill, fence_vrt);
    end

    // Hypervisor fence: virtual first, then privilege gate.
    always_comb begin
        hf_ok = ctx.m || (ctx.s && !ctx.v);
        hfence_verdict = virt_first(ctx.v, !hf_ok);
    end

    // Guest fence: translation-trap in host supervisor outranks all.
    always_comb begin
        hg_pre_ill = ctx.s && !ctx.v && ms_xlat_trap;
        if (hg_pre_ill) begin
            hgfence_verdict = '{virt_trap: 1'b0, illegal: 1'b1, exec: 1'b0};
        end else begin
            hgfence_verdict = hfence_verdict;
        end
    end

endmodule

// File: rtl/priv_wait_fence_decider.sv
module priv_wait_fence_decider
    import twd_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [1:0]        cur_priv,
    input  logic              virt_on,
    input  logic              has_smode,
    input  logic              ms_wait_trap,
    input  logic              ms_xlat_trap,
    input  logic              hs_wait_trap,
    input  logic              hs_xlat_trap,
    output logic              rsp_valid,
    output logic              rsp_exec,
    output logic              rsp_illegal,
    output logic              rsp_virtual
);

    ctx_t     ctx;
    verdict_t per_kind [KIND_W];
    verdict_t merged   [KIND_W+1];
    verdict_t decided;
    verdict_t resp_d;
    verdict_t resp_q;
    logic     valid_q;

    assign ctx = decode_ctx(cur_priv, virt_on);

    twd_wait_unit u_wait (
        .ctx          (ctx),
        .has_smode    (has_smode),
        .ms_wait_trap (ms_wait_trap),
        .hs_wait_trap (hs_wait_trap),
        .wfi_verdict  (per_kind[KIND_WFI]),
        .wrs_verdict  (per_kind[KIND_WRS])
    );

    twd_fence_unit u_fence (
        .ctx             (ctx),
        .ms_xlat_trap    (ms_xlat_trap),
        .hs_xlat_trap    (hs_xlat_trap),
        .fence_verdict   (per_kind[KIND_FENCE]),
        .hfence_verdict  (per_kind[KIND_HFNC]),
        .hgfence_verdict (per_kind[KIND_HGFNC])
    );

    // One-hot select of the verdict for the requested kind.
    assign merged[0] = VERDICT_NONE;
    for (genvar k = 0; k < KIND_W; k++) begin : g_sel
        assign merged[k+1] = merged[k] | (req_kind[k] ? per_kind[k] : VERDICT_NONE);
    end

    always_comb begin
        if (is_onehot(req_kind)) begin
            decided = merged[KIND_W];
        end else begin
            decided = '{virt_trap: 1'b0, illegal: 1'b1, exec: 1'b0};
        end
        resp_d = req_valid ? decided : VERDICT_NONE;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q <= 1'b0;
                resp_q  <= VERDICT_NONE;
            end else begin
                valid_q <= req_valid;
                resp_q  <= resp_d;
            end
        end

        AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
            req_valid |=> rsp_valid);                                        // R2
        AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
            !req_valid |=> !rsp_exec && !rsp_illegal && !rsp_virtual);       // R2
        AST_BAD_KIND_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
            (req_valid && $countones(req_kind) != 1) |=> rsp_illegal);       // R10
        AST_HFENCE_VIRT: assert property (@(posedge clk) disable iff (rst)
            (req_valid && req_kind == 5'b01000 && virt_on) |=> rsp_virtual); // R8
        AST_GUEST_TVM_FIRST: assert property (@(posedge clk) disable iff (rst)
            (req_valid && req_kind == 5'b10000 && cur_priv == 2'b01
             && !virt_on && ms_xlat_trap) |=> rsp_illegal);                  // R9
        AST_WRS_MACHINE_RUNS: assert property (@(posedge clk) disable iff (rst)
            (req_valid && req_kind == 5'b00010 && cur_priv == 2'b11
             && !virt_on) |=> rsp_exec);                                     // R5
    end else begin : g_comb
        assign valid_q = req_valid;
        assign resp_q  = resp_d;
    end

    assign rsp_valid   = valid_q;
    assign rsp_exec    = resp_q.exec;
    assign rsp_illegal = resp_q.illegal;
    assign rsp_virtual = resp_q.virt_trap;

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_exec, rsp_illegal, rsp_virtual}) == 1); // R2

endmodule

// File: tb/test_priv_wait_fence_decider.sv
module test_priv_wait_fence_decider;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic [4:0] req_kind;
    logic [1:0] cur_priv;
    logic       virt_on, has_smode;
    logic       ms_wait_trap, ms_xlat_trap, hs_wait_trap, hs_xlat_trap;
    logic       rsp_valid, rsp_exec, rsp_illegal, rsp_virtual;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    priv_wait_fence_decider i_priv_wait_fence_decider (
        .clk, .rst, .req_valid, .req_kind, .cur_priv, .virt_on, .has_smode,
        .ms_wait_trap, .ms_xlat_trap, .hs_wait_trap, .hs_xlat_trap,
        .rsp_valid, .rsp_exec, .rsp_illegal, .rsp_virtual
    );

    // Reference: returns {valid, virtual, illegal, exec}.
    function automatic logic [3:0] model(input logic val, input logic [4:0] k,
                                         input logic [1:0] p, input logic v,
                                         input logic hs, input logic tw,
                                         input logic tvm, input logic vtw,
                                         input logic vtvm);
        logic mm, ss, uu;
        int   ones;
        mm = (p == 2'b11) || (p == 2'b10);
        ss = (p == 2'b01);
        uu = (p == 2'b00);
        ones = $countones(k);
        if (!val) return 4'b0000;
        if (ones != 1) return 4'b1010;
        case (1'b1)
            k[0]: begin
                if (((ss || (!hs && uu)) && tw) || (hs && uu && !v)) return 4'b1010;
                if (v && (uu || (ss && vtw))) return 4'b1100;
                return 4'b1001;
            end
            k[1]: begin
                if (v && (ss || uu) && vtw && !tw) return 4'b1100;
                if (!mm && tw) return 4'b1010;
                return 4'b1001;
            end
            k[2]: begin
                if (!v && (uu || (ss && tvm))) return 4'b1010;
                if (v && (uu || vtvm)) return 4'b1100;
                return 4'b1001;
            end
            default: begin
                if (k[4] && ss && !v && tvm) return 4'b1010;
                if (v) return 4'b1100;
                if (mm || ss) return 4'b1001;
                return 4'b1010;
            end
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] k, input logic [1:0] p);
        if ($countones(k) != 1) return "R10";
        if (p == 2'b10) return "R11";
        if (k[0]) return "R3/R4";
        if (k[1]) return "R5";
        if (k[2]) return "R6/R7";
        if (k[3]) return "R8";
        return "R9";
    endfunction

    task automatic check(input logic [3:0] exp, input string tag);
        logic [3:0] got;
        got = {rsp_valid, rsp_virtual, rsp_illegal, rsp_exec};
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s kind=%b priv=%b got=%b exp=%b", tag, req_kind,
                     cur_priv, got, exp);
        end
    endtask

    // Drive at falling edge, sample at the next falling edge (one register).
    task automatic apply(input logic val, input logic [4:0] k, input logic [1:0] p,
                         input logic [5:0] bits);
        logic [3:0] exp;
        req_valid = val; req_kind = k; cur_priv = p;
        {virt_on, has_smode, ms_wait_trap, ms_xlat_trap, hs_wait_trap, hs_xlat_trap} = bits;
        exp = model(val, k, p, bits[5], bits[4], bits[3], bits[2], bits[1], bits[0]);
        @(negedge clk);
        check(exp, val ? tag_of(k, p) : "R2");
    endtask

    initial begin
        rst = 1'b1;
        req_valid = 1'b1; req_kind = 5'b00001; cur_priv = 2'b00;
        {virt_on, has_smode, ms_wait_trap, ms_xlat_trap, hs_wait_trap, hs_xlat_trap} = '0;
        repeat (3) @(negedge clk);
        check(4'b0000, "R1");                      // reset state
        rst = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        check(4'b0000, "R1");                      // first cycle after reset

        // Directed precedence cases.
        apply(1'b1, 5'b00010, 2'b01, 6'b101010);   // R5: both wait traps, TW wins
        apply(1'b1, 5'b00010, 2'b01, 6'b100010);   // R5: virtual
        apply(1'b1, 5'b10000, 2'b01, 6'b000100);   // R9: guest fence TVM
        apply(1'b1, 5'b00001, 2'b01, 6'b101010);   // R3 beats R4
        apply(1'b1, 5'b00001, 2'b00, 6'b010000);   // R3: user, S present
        apply(1'b1, 5'b00100, 2'b01, 6'b100001);   // R7
        apply(1'b1, 5'b01000, 2'b00, 6'b000000);   // R8: user host illegal
        apply(1'b1, 5'b00000, 2'b11, 6'b000000);   // R10: no kind
        apply(1'b1, 5'b00110, 2'b11, 6'b000000);   // R10: two kinds
        apply(1'b1, 5'b00010, 2'b10, 6'b001000);   // R11: reserved acts as machine
        apply(1'b0, 5'b00001, 2'b00, 6'b010000);   // R2: idle gives nothing

        // Exhaustive enumeration of all legal kinds and contexts.
        for (int k = 0; k < 5; k++)
            for (int p = 0; p < 4; p++)
                for (int b = 0; b < 64; b++)
                    apply(1'b1, 5'(1 << k), 2'(p), 6'(b));

        // Random mix with a fixed seed.
        void'($urandom(32'd4711));
        for (int i = 0; i < 600; i++) begin
            logic [4:0] rk;
            rk = ($urandom % 4 == 0) ? 5'($urandom) : 5'(1 << ($urandom % 5));
            apply(($urandom % 5) != 0, rk, 2'($urandom), 6'($urandom));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule